// File: doc/BRIEF.md
# Dual-Window ADC Threshold Comparator

The comparator sits behind an analog-to-digital converter and looks at every finished conversion result. A result arrives as a one-cycle strobe carrying a channel number and a sample value. The channel's select bit picks one of two threshold windows, each made of a low and a high limit. The block then classifies the sample as below, inside or above that window. It also compares the sample with the previous sample on the same channel and reports whether the signal passed the low limit, and in which direction.

Each channel has a two-bit event mode. The mode decides whether a sample outside the window, or a sample that crossed the low limit, latches that channel's comparison flag. Software clears a flag by writing a one to its bit. A single summary interrupt stays high while any flag is set. The classification codes come out one clock after the strobe, next to a valid pulse and the channel number, so a result register or DMA path downstream can store them beside the sample.

Top module: `adc_window_cmp`

## Requirements
- R1: The threshold pair is chosen per channel: `thr_sel[n]` = 1 compares channel n against `thr_lo1`/`thr_hi1`, and `thr_sel[n]` = 0 compares it against `thr_lo0`/`thr_hi0`.
- R2: `range_code` is 2 when value < low, otherwise 3 when value > high, otherwise 0. A value equal to either limit is inside. Code 1 never appears.
- R3: `cross_code` is 2 when the previous sample of the channel was >= low and the current one is < low. It is 3 when the previous sample was < low and the current one is >= low. It is 0 otherwise. Both tests use the low limit selected for the current sample. Code 1 never appears.
- R4: The first sample on a channel after reset gives `cross_code` 0. Each channel keeps its own previous sample.
- R5: The mode of channel n is `int_mode[2n+1:2n]`. Mode 1 sets `cmp_flags[n]` when `range_code` is not 0. Mode 2 sets it when `cross_code` is not 0. Modes 0 and 3 never set it.
- R6: A 1 in `flag_clr[n]` clears `cmp_flags[n]` on the next clock. If an event for channel n arrives in the same cycle, the set wins.
- R7: `cmp_irq` is high exactly when at least one bit of `cmp_flags` is set.
- R8: `out_valid`, `out_chan`, `range_code` and `cross_code` are registered one clock after `res_valid`. The codes hold their last value while `out_valid` is low. Flags change only on an event or a clear.
- R9: Synchronous reset drives `out_valid`, `cmp_flags` and `cmp_irq` low and erases the sample history of every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | CH_W | Channel of the result |
| res_value | input | DATA_W | Sample value |
| thr_lo0 | input | DATA_W | Low limit, window 0 |
| thr_hi0 | input | DATA_W | High limit, window 0 |
| thr_lo1 | input | DATA_W | Low limit, window 1 |
| thr_hi1 | input | DATA_W | High limit, window 1 |
| thr_sel | input | NUM_CH | Window select per channel |
| int_mode | input | 2*NUM_CH | Event mode per channel |
| flag_clr | input | NUM_CH | Write-one-to-clear for flags |
| out_valid | output | 1 | Classification valid |
| out_chan | output | CH_W | Channel of the classification |
| range_code | output | 2 | Window classification |
| cross_code | output | 2 | Low-limit crossing direction |
| cmp_flags | output | NUM_CH | Per-channel comparison flags |
| cmp_irq | output | 1 | Summary comparison interrupt |

## Verification
The bench builds the block with five channels and 6-bit samples. With only 64 possible values, random samples land exactly on a limit often. This exercises the equality edges of the window and the crossing boundary, and random limits also give windows with low above high. Five channels on a 3-bit channel field leave non-power-of-two indexing in play. A reference model follows all five histories and flags every cycle, including clears that coincide with events.

// File: rtl/adc_wc_pkg.sv
package adc_wc_pkg;
  typedef enum logic [1:0] {
    RNG_IN    = 2'd0,
    RNG_RSVD  = 2'd1,
    RNG_BELOW = 2'd2,
    RNG_ABOVE = 2'd3
  } rng_t;

  typedef enum logic [1:0] {
    XC_NONE = 2'd0,
    XC_RSVD = 2'd1,
    XC_DOWN = 2'd2,
    XC_UP   = 2'd3
  } xc_t;

  typedef enum logic [1:0] {
    MD_OFF   = 2'd0,
    MD_OUT   = 2'd1,
    MD_CROSS = 2'd2,
    MD_SPARE = 2'd3
  } md_t;
endpackage

// File: rtl/adc_wc_classify.sv
module adc_wc_classify
  import adc_wc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] prev,
  input  logic              has_prev,
  output rng_t              rng,
  output xc_t               xc
);
  logic now_below;
  logic was_below;

  assign now_below = value < lo;
  assign was_below = prev < lo;

  always_comb begin
    if (now_below)      rng = RNG_BELOW;
    else if (value > hi) rng = RNG_ABOVE;
    else                rng = RNG_IN;
  end

  always_comb begin
    xc = XC_NONE;
    if (has_prev) begin
      if (!was_below && now_below)      xc = XC_DOWN;
      else if (was_below && !now_below) xc = XC_UP;
    end
  end
endmodule

// File: rtl/adc_wc_history.sv
module adc_wc_history #(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [DATA_W-1:0] rd_prev,
  output logic              rd_seen,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [DATA_W-1:0] wr_value
);
  logic [DATA_W-1:0] prev_mem [NUM_CH];
  logic [NUM_CH-1:0] seen;

  always_ff @(posedge clk) begin
    if (wr_en) prev_mem[wr_chan] <= wr_value;
  end

  always_ff @(posedge clk) begin
    if (rst)        seen <= '0;
    else if (wr_en) seen[wr_chan] <= 1'b1;
  end

  assign rd_prev = prev_mem[rd_chan];
  assign rd_seen = seen[rd_chan];
endmodule

// File: rtl/adc_wc_flags.sv
module adc_wc_flags #(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] flags,
  output logic              irq
);
  logic [NUM_CH-1:0] flags_nxt;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
    assign flags_nxt[n] = set_vec[n] | (flags[n] & ~clr_vec[n]);
    always_ff @(posedge clk) begin
      if (rst) flags[n] <= 1'b0;
      else     flags[n] <= flags_nxt[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |flags_nxt;
  end
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
  import adc_wc_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                res_valid,
  input  logic [CH_W-1:0]     res_chan,
  input  logic [DATA_W-1:0]   res_value,
  input  logic [DATA_W-1:0]   thr_lo0,
  input  logic [DATA_W-1:0]   thr_hi0,
  input  logic [DATA_W-1:0]   thr_lo1,
  input  logic [DATA_W-1:0]   thr_hi1,
  input  logic [NUM_CH-1:0]   thr_sel,
  input  logic [2*NUM_CH-1:0] int_mode,
  input  logic [NUM_CH-1:0]   flag_clr,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_chan,
  output logic [1:0]          range_code,
  output logic [1:0]          cross_code,
  output logic [NUM_CH-1:0]   cmp_flags,
  output logic                cmp_irq
);
  localparam int unsigned LAST_CH = NUM_CH - 1;

  logic              chan_ok;
  logic              take;
  logic [CH_W-1:0]   ch_idx;
  logic              use_set1;
  logic [DATA_W-1:0] lo_sel;
  logic [DATA_W-1:0] hi_sel;
  md_t               mode;
  logic [DATA_W-1:0] prev_val;
  logic              prev_seen;
  rng_t              rng;
  xc_t               xc;
  logic              evt;
  logic [NUM_CH-1:0] set_vec;

  assign chan_ok  = 32'(res_chan) <= LAST_CH;
  assign take     = res_valid & chan_ok;
  assign ch_idx   = chan_ok ? res_chan : '0;
  assign use_set1 = thr_sel[ch_idx];
  assign lo_sel   = use_set1 ? thr_lo1 : thr_lo0;
  assign hi_sel   = use_set1 ? thr_hi1 : thr_hi0;
  assign mode     = md_t'(int_mode[{ch_idx, 1'b0} +: 2]);

  adc_wc_history #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
  ) u_hist (
    .clk      (clk),
    .rst      (rst),
    .rd_chan  (ch_idx),
    .rd_prev  (prev_val),
    .rd_seen  (prev_seen),
    .wr_en    (take),
    .wr_chan  (ch_idx),
    .wr_value (res_value)
  );

  adc_wc_classify #(
    .DATA_W (DATA_W)
  ) u_cls (
    .value    (res_value),
    .lo       (lo_sel),
    .hi       (hi_sel),
    .prev     (prev_val),
    .has_prev (prev_seen),
    .rng      (rng),
    .xc       (xc)
  );

  always_comb begin
    unique case (mode)
      MD_OUT:   evt = (rng != RNG_IN);
      MD_CROSS: evt = (xc != XC_NONE);
      default:  evt = 1'b0;
    endcase
  end

  always_comb begin
    set_vec = '0;
    if (take && evt) set_vec[ch_idx] = 1'b1;
  end

  adc_wc_flags #(
    .NUM_CH (NUM_CH)
  ) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (flag_clr),
    .flags   (cmp_flags),
    .irq     (cmp_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      range_code <= RNG_IN;
      cross_code <= XC_NONE;
    end else begin
      out_valid <= take;
      if (take) begin
        out_chan   <= ch_idx;
        range_code <= rng;
        cross_code <= xc;
      end
    end
  end
endmodule

// File: rtl/adc_wc_checker.sv
module adc_wc_checker #(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic [NUM_CH-1:0] flag_clr,
  input logic              out_valid,
  input logic [1:0]        range_code,
  input logic [1:0]        cross_code,
  input logic [NUM_CH-1:0] cmp_flags,
  input logic              cmp_irq
);
  AST_RANGE_NOT_RESERVED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> range_code != 2'd1); // R2

  AST_CROSS_NOT_RESERVED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cross_code != 2'd1); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(res_valid) && $past(flag_clr) != '0)
      |-> (cmp_flags & $past(flag_clr)) == '0); // R6

  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    cmp_irq == (cmp_flags != '0)); // R7

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(res_valid) && $past(flag_clr) == '0)
      |-> $stable(cmp_flags)); // R8

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && cmp_flags == '0 && !cmp_irq)); // R9
endmodule

bind adc_window_cmp adc_wc_checker #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .res_valid  (res_valid),
  .flag_clr   (flag_clr),
  .out_valid  (out_valid),
  .range_code (range_code),
  .cross_code (cross_code),
  .cmp_flags  (cmp_flags),
  .cmp_irq    (cmp_irq)
);

// File: tb/adc_window_cmp_test.sv
`timescale 1ns/1ps
module adc_window_cmp_test;
  localparam int NCH = 5;
  localparam int DW  = 6;
  localparam int CW  = $clog2(NCH);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            res_valid = 1'b0;
  logic [CW-1:0]   res_chan = '0;
  logic [DW-1:0]   res_value = '0;
  logic [DW-1:0]   thr_lo0 = '0, thr_hi0 = '0, thr_lo1 = '0, thr_hi1 = '0;
  logic [NCH-1:0]  thr_sel = '0;
  logic [2*NCH-1:0] int_mode = '0;
  logic [NCH-1:0]  flag_clr = '0;
  logic            out_valid;
  logic [CW-1:0]   out_chan;
  logic [1:0]      range_code, cross_code;
  logic [NCH-1:0]  cmp_flags;
  logic            cmp_irq;

  always #2.5 clk = ~clk;

  adc_window_cmp #(.NUM_CH(NCH), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_chan(res_chan),
    .res_value(res_value), .thr_lo0(thr_lo0), .thr_hi0(thr_hi0),
    .thr_lo1(thr_lo1), .thr_hi1(thr_hi1), .thr_sel(thr_sel),
    .int_mode(int_mode), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_chan(out_chan), .range_code(range_code), .cross_code(cross_code),
    .cmp_flags(cmp_flags), .cmp_irq(cmp_irq)
  );

  int errors = 0;
  int checks = 0;
  string cur_tag = "R9";

  // reference model state
  int  m_prev [NCH];
  bit  m_seen [NCH];
  bit  e_valid;
  int  e_chan, e_rng, e_xc;
  bit [NCH-1:0] e_flags;
  bit  e_irq;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) m_seen[i] = 1'b0;
      e_valid = 0; e_flags = '0; e_irq = 0;
      e_chan = 0; e_rng = 0; e_xc = 0;
    end else begin
      bit [NCH-1:0] nf;
      nf = e_flags & ~flag_clr;
      e_valid = res_valid;
      if (res_valid) begin
        int c, v, lo, hi, md;
        c  = int'(res_chan);
        v  = int'(res_value);
        lo = thr_sel[c] ? int'(thr_lo1) : int'(thr_lo0);
        hi = thr_sel[c] ? int'(thr_hi1) : int'(thr_hi0);
        e_chan = c;
        e_rng = (v < lo) ? 2 : ((v > hi) ? 3 : 0);
        e_xc = 0;
        if (m_seen[c]) begin
          if (m_prev[c] >= lo && v < lo) e_xc = 2;
          else if (m_prev[c] < lo && v >= lo) e_xc = 3;
        end
        md = int'(int_mode[2*c +: 2]);
        if ((md == 1 && e_rng != 0) || (md == 2 && e_xc != 0)) nf[c] = 1'b1;
        m_prev[c] = v;
        m_seen[c] = 1'b1;
      end
      e_flags = nf;
      e_irq = (nf != '0);
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("out_valid", int'(out_valid), int'(e_valid));
      if (e_valid) begin
        check("out_chan", int'(out_chan), e_chan);
        check("range_code", int'(range_code), e_rng);
        check("cross_code", int'(cross_code), e_xc);
      end
      check("cmp_flags", int'(cmp_flags), int'(e_flags));
      check("cmp_irq", int'(cmp_irq), int'(e_irq));
    end
  end

  task automatic sample(int c, int v);
    @(negedge clk);
    res_valid = 1'b1; res_chan = CW'(c); res_value = DW'(v);
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic clear(bit [NCH-1:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: state straight after reset
    check("reset out_valid", int'(out_valid), 0);
    check("reset flags", int'(cmp_flags), 0);
    check("reset irq", int'(cmp_irq), 0);

    thr_lo0 = 10; thr_hi0 = 40; thr_lo1 = 20; thr_hi1 = 30;
    thr_sel = 5'b00010;
    int_mode = '0;
    int_mode[1:0] = 2'd1;   // ch0 outside
    int_mode[3:2] = 2'd2;   // ch1 crossing
    int_mode[5:4] = 2'd3;   // ch2 spare mode

    cur_tag = "R2";
    sample(0, 10); sample(0, 40); sample(0, 9); sample(0, 41);
    cur_tag = "R8";
    repeat (3) @(negedge clk);
    cur_tag = "R6";
    clear(5'b00001);
    cur_tag = "R4";
    sample(1, 5);
    cur_tag = "R3";
    sample(1, 20); sample(1, 19); sample(1, 19);
    cur_tag = "R1";
    sample(0, 25); sample(1, 35); sample(0, 15); sample(1, 15);
    cur_tag = "R5";
    sample(2, 0); sample(2, 63);
    int_mode[1:0] = 2'd0; sample(0, 0);
    cur_tag = "R6";
    clear(5'b00011);
    int_mode[1:0] = 2'd1;
    @(negedge clk);
    res_valid = 1'b1; res_chan = 0; res_value = 2; flag_clr = 5'b00001;
    @(negedge clk);
    res_valid = 1'b0; flag_clr = '0;
    cur_tag = "R7";
    clear(5'b11111);
    repeat (2) @(negedge clk);
    cur_tag = "R9";
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    sample(1, 50);

    cur_tag = "R3";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      res_valid = ($urandom_range(0, 3) != 0);
      res_chan  = CW'($urandom_range(0, NCH-1));
      res_value = DW'($urandom);
      flag_clr  = ($urandom_range(0, 7) == 0) ? NCH'($urandom) : '0;
      if ($urandom_range(0, 49) == 0) begin
        thr_lo0 = DW'($urandom); thr_hi0 = DW'($urandom);
        thr_lo1 = DW'($urandom); thr_hi1 = DW'($urandom);
        thr_sel = NCH'($urandom); int_mode = (2*NCH)'($urandom);
      end
    end
    @(negedge clk);
    res_valid = 1'b0; flag_clr = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule